// File: doc/BRIEF.md
# Bus Slave Own-Address Matcher

This block decides whether the bytes that open a two-wire serial bus transfer are addressed to this device. It holds the device's own address byte, watches the START and STOP events reported by the bus front end, and compares only the byte or bytes that arrive right after a START. In short-address mode a single byte decides the outcome. In long-address mode the first byte and a second byte must both agree. The byte shifter and clock generation are outside the block. The shifter hands over each complete byte with a one-cycle strobe, and it takes back an acknowledge decision one cycle later.

The own-address byte holds the seven address bits in its upper part and a direction flag in bit 0. The flag is cleared by hardware whenever a STOP is seen. During the address phase the acknowledge decision follows the comparison result, which overrides the software acknowledge level. After a match the block stays matched until the transfer ends with a STOP or is restarted with a START. After a mismatch it ignores the rest of the transfer.

Top module: `i2c_addr_matcher`

## Requirements
- R1: After reset, match_o, ack_vld_o and ack_o are 0 and own_addr_o is 0x00.
- R2: A cycle with addr_wr_i high loads addr_wdata_i into own_addr_o, visible after that clock edge.
- R3: In short mode (mode10_i = 0), the first byte after START matches when byte_i[7:1] equals own_addr_o[7:1], whatever the value of bit 0 on either side. A match sets match_o after that edge, and a mismatch leaves it at 0.
- R4: In long mode (mode10_i = 1), the first byte after START is compared with all eight bits of own_addr_o, and match_o stays 0 after it.
- R5: In long mode, the second byte after START is compared with lo_addr_i. match_o is set only when both bytes agree.
- R6: For each address-phase byte, ack_vld_o pulses one cycle after the byte strobe. ack_o is 1 (SDA low) exactly when that byte agreed and ack_level_i is 0. When ack_level_i is 1, ack_o is 0.
- R7: After an address byte mismatches, further bytes produce no ack_vld_o and no match until the next START.
- R8: Bytes that arrive with no START since reset or since the last STOP produce no ack_vld_o.
- R9: match_o holds until a STOP or a START, and either one clears it on the next edge. A START restarts the address phase.
- R10: STOP clears own_addr_o[0] on the next edge and leaves bits 7..1 unchanged. This also holds when a write happens in the same cycle, in which case bit 0 of the written value is forced to 0.
- R11: Once matched, every data byte produces an ack_vld_o pulse with ack_o equal to the inverse of ack_level_i.
- R12: When START and STOP arrive in the same cycle, STOP wins and the block returns to idle. A byte strobed in the same cycle as START or STOP is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_wr_i | input | 1 | Write strobe for the own-address byte |
| addr_wdata_i | input | 8 | Value to write: address in bits 7..1, direction flag in bit 0 |
| lo_addr_i | input | 8 | Second address byte expected in long mode |
| mode10_i | input | 1 | 0 = short (7-bit) addressing, 1 = long (10-bit) addressing |
| ack_level_i | input | 1 | Software acknowledge level: 0 = acknowledge, 1 = no acknowledge |
| start_i | input | 1 | One-cycle pulse: START detected |
| stop_i | input | 1 | One-cycle pulse: STOP detected |
| byte_i | input | 8 | Received byte |
| byte_vld_i | input | 1 | One-cycle strobe: byte_i is complete |
| own_addr_o | output | 8 | Current own-address byte |
| match_o | output | 1 | Device addressed in the current transfer |
| ack_vld_o | output | 1 | One-cycle pulse: ack_o is valid for the last byte |
| ack_o | output | 1 | 1 = drive SDA low (acknowledge) |

## Verification
The bench targets a first byte whose bit 0 differs from the register. In short mode such a byte must match, so a design that compares all eight bits would answer NACK. In long mode the same byte must be rejected, so a design that skips bit 0 would accept a foreign master. The bench also sends a long-mode transfer where the first byte is right and the second is wrong. A design that set the match after the first byte would report the device as addressed. It checks that bytes after a mismatch, and bytes before any START, draw no acknowledge pulse, and that STOP clears only the direction flag, including when a register write lands in the same cycle. It also drives START and STOP together to confirm that STOP takes priority.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_FIRST,
        PH_SECOND,
        PH_DATA,
        PH_REJECT
    } phase_e;

    typedef struct packed {
        phase_e phase;
        logic   match;
        logic   ack_vld;
        logic   ack;
    } ctl_s;

endpackage

// File: rtl/i2c_am_addr_reg.sv
module i2c_am_addr_reg #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [AW-1:0] wdata_i,
    input  logic          stop_i,
    output logic [AW-1:0] addr_o
);

    logic [AW-1:0] addr_d, addr_q;

    always_comb begin
        addr_d = addr_q;
        if (wr_i) begin
            addr_d = wdata_i;
        end
        // direction flag drops on STOP, even over a same-cycle write
        if (stop_i) begin
            addr_d[0] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else begin
            addr_q <= addr_d;
        end
    end

    assign addr_o = addr_q;

endmodule

// File: rtl/i2c_am_cmp.sv
module i2c_am_cmp #(
    parameter int AW = 8
) (
    input  logic [AW-1:0] rx_i,
    input  logic [AW-1:0] own_i,
    input  logic [AW-1:0] lo_i,
    input  logic          full_i,
    output logic          hi_eq_o,
    output logic          lo_eq_o
);

    localparam int UPPER = AW - 1;

    logic [AW-1:0] hi_bit_eq;
    logic [AW-1:0] lo_bit_eq;

    for (genvar g = 0; g < AW; g++) begin : g_bit
        assign hi_bit_eq[g] = ~(rx_i[g] ^ own_i[g]);
        assign lo_bit_eq[g] = ~(rx_i[g] ^ lo_i[g]);
    end

    // bit 0 only takes part in the long-mode first byte
    assign hi_eq_o = (&hi_bit_eq[UPPER:1]) & (hi_bit_eq[0] | ~full_i);
    assign lo_eq_o = &lo_bit_eq;

endmodule

// File: rtl/i2c_addr_matcher.sv
module i2c_addr_matcher #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          addr_wr_i,
    input  logic [AW-1:0] addr_wdata_i,
    input  logic [AW-1:0] lo_addr_i,
    input  logic          mode10_i,
    input  logic          ack_level_i,
    input  logic          start_i,
    input  logic          stop_i,
    input  logic [AW-1:0] byte_i,
    input  logic          byte_vld_i,
    output logic [AW-1:0] own_addr_o,
    output logic          match_o,
    output logic          ack_vld_o,
    output logic          ack_o
);

    import i2c_am_pkg::*;

    logic [AW-1:0] own_addr;
    logic          hi_eq;
    logic          lo_eq;
    ctl_s          ctl_d, ctl_q;

    i2c_am_addr_reg #(.AW(AW)) addr_reg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (addr_wr_i),
        .wdata_i (addr_wdata_i),
        .stop_i  (stop_i),
        .addr_o  (own_addr)
    );

    i2c_am_cmp #(.AW(AW)) cmp_i (
        .rx_i    (byte_i),
        .own_i   (own_addr),
        .lo_i    (lo_addr_i),
        .full_i  (mode10_i),
        .hi_eq_o (hi_eq),
        .lo_eq_o (lo_eq)
    );

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.ack_vld = 1'b0;
        ctl_d.ack     = 1'b0;
        if (stop_i) begin
            ctl_d.phase = PH_IDLE;
            ctl_d.match = 1'b0;
        end else if (start_i) begin
            ctl_d.phase = PH_FIRST;
            ctl_d.match = 1'b0;
        end else if (byte_vld_i) begin
            unique case (ctl_q.phase)
                PH_FIRST: begin
                    ctl_d.ack_vld = 1'b1;
                    ctl_d.ack     = hi_eq & ~ack_level_i;
                    if (!hi_eq) begin
                        ctl_d.phase = PH_REJECT;
                    end else if (mode10_i) begin
                        ctl_d.phase = PH_SECOND;
                    end else begin
                        ctl_d.phase = PH_DATA;
                        ctl_d.match = 1'b1;
                    end
                end
                PH_SECOND: begin
                    ctl_d.ack_vld = 1'b1;
                    ctl_d.ack     = lo_eq & ~ack_level_i;
                    if (lo_eq) begin
                        ctl_d.phase = PH_DATA;
                        ctl_d.match = 1'b1;
                    end else begin
                        ctl_d.phase = PH_REJECT;
                    end
                end
                PH_DATA: begin
                    ctl_d.ack_vld = 1'b1;
                    ctl_d.ack     = ~ack_level_i;
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{phase: PH_IDLE, match: 1'b0, ack_vld: 1'b0, ack: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign own_addr_o = own_addr;
    assign match_o    = ctl_q.match;
    assign ack_vld_o  = ctl_q.ack_vld;
    assign ack_o      = ctl_q.ack;

endmodule

// File: rtl/i2c_addr_matcher_chk.sv
module i2c_addr_matcher_chk #(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          addr_wr_i,
    input logic          ack_level_i,
    input logic          start_i,
    input logic          stop_i,
    input logic          byte_vld_i,
    input logic [AW-1:0] own_addr_o,
    input logic          match_o,
    input logic          ack_vld_o,
    input logic          ack_o
);

    // R9
    stop_clears_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> !match_o);

    // R9
    start_clears_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !match_o);

    // R10
    stop_drops_dir_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> !own_addr_o[0]);

    // R10
    stop_keeps_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !addr_wr_i) |=> (own_addr_o[AW-1:1] == $past(own_addr_o[AW-1:1])));

    // R6
    ack_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> ack_vld_o);

    // R6
    no_ack_at_high_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld_i && ack_level_i) |=> !ack_o);

    // R8
    no_pulse_without_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_vld_i |=> !ack_vld_o);

    // R5
    match_rise_on_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(match_o) |-> ack_vld_o);

endmodule

bind i2c_addr_matcher i2c_addr_matcher_chk #(.AW(AW)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr_wr_i   (addr_wr_i),
    .ack_level_i (ack_level_i),
    .start_i     (start_i),
    .stop_i      (stop_i),
    .byte_vld_i  (byte_vld_i),
    .own_addr_o  (own_addr_o),
    .match_o     (match_o),
    .ack_vld_o   (ack_vld_o),
    .ack_o       (ack_o)
);

// File: tb/i2c_addr_matcher_tb_top.sv
module i2c_addr_matcher_tb_top;

    // 50 MHz: 20 time-unit period
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       addr_wr_i = 1'b0;
    logic [7:0] addr_wdata_i = '0;
    logic [7:0] lo_addr_i = '0;
    logic       mode10_i = 1'b0;
    logic       ack_level_i = 1'b0;
    logic       start_i = 1'b0;
    logic       stop_i = 1'b0;
    logic [7:0] byte_i = '0;
    logic       byte_vld_i = 1'b0;
    logic [7:0] own_addr_o;
    logic       match_o;
    logic       ack_vld_o;
    logic       ack_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // model state: 0 idle, 1 first, 2 second, 3 data, 4 reject
    int       m_ph = 0;
    bit       m_match = 0;
    bit       m_ackv = 0;
    bit       m_ack = 0;
    bit [7:0] m_reg = '0;

    always #10 clk = ~clk;

    i2c_addr_matcher #(.AW(8)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .addr_wr_i    (addr_wr_i),
        .addr_wdata_i (addr_wdata_i),
        .lo_addr_i    (lo_addr_i),
        .mode10_i     (mode10_i),
        .ack_level_i  (ack_level_i),
        .start_i      (start_i),
        .stop_i       (stop_i),
        .byte_i       (byte_i),
        .byte_vld_i   (byte_vld_i),
        .own_addr_o   (own_addr_o),
        .match_o      (match_o),
        .ack_vld_o    (ack_vld_o),
        .ack_o        (ack_o)
    );

    function automatic bit first_ok(input bit [7:0] b, input bit [7:0] r, input bit long_m);
        if (long_m) return b == r;
        return b[7:1] == r[7:1];
    endfunction

    task automatic compare(input string tag);
        checks++;
        if (match_o !== m_match || ack_vld_o !== m_ackv || ack_o !== m_ack || own_addr_o !== m_reg) begin
            errors++;
            $display("FAIL %s: actual match=%b ackv=%b ack=%b addr=%h expected match=%b ackv=%b ack=%b addr=%h",
                     tag, match_o, ack_vld_o, ack_o, own_addr_o, m_match, m_ackv, m_ack, m_reg);
        end
    endtask

    task automatic cyc(input bit st, input bit sp, input bit bv, input bit [7:0] b,
                       input bit wr, input bit [7:0] wd, input string tag);
        bit ok;
        @(negedge clk);
        start_i = st; stop_i = sp; byte_vld_i = bv; byte_i = b;
        addr_wr_i = wr; addr_wdata_i = wd;
        @(posedge clk);
        m_ackv = 0; m_ack = 0;
        if (sp) begin
            m_ph = 0; m_match = 0;
        end else if (st) begin
            m_ph = 1; m_match = 0;
        end else if (bv) begin
            case (m_ph)
                1: begin
                    ok = first_ok(b, m_reg, mode10_i);
                    m_ackv = 1; m_ack = ok && !ack_level_i;
                    if (!ok) m_ph = 4;
                    else if (mode10_i) m_ph = 2;
                    else begin m_ph = 3; m_match = 1; end
                end
                2: begin
                    ok = (b == lo_addr_i);
                    m_ackv = 1; m_ack = ok && !ack_level_i;
                    if (ok) begin m_ph = 3; m_match = 1; end
                    else m_ph = 4;
                end
                3: begin m_ackv = 1; m_ack = !ack_level_i; end
                default: ;
            endcase
        end
        if (wr) m_reg = wd;
        if (sp) m_reg[0] = 1'b0;
        #1;
        compare(tag);
    endtask

    task automatic idle(input string tag);
        cyc(0, 0, 0, 8'h00, 0, 8'h00, tag);
    endtask

    task automatic send(input bit [7:0] b, input string tag);
        cyc(0, 0, 1, b, 0, 8'h00, tag);
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1c2a));
        repeat (3) @(posedge clk);
        #1;
        compare("R1 in reset");
        @(negedge clk);
        rst_n = 1'b1;
        idle("R1 after reset");

        // register load
        cyc(0, 0, 0, 8'h00, 1, 8'hA4, "R2 write A4");
        idle("R2 hold");

        // bytes before any START
        send(8'hA4, "R8 no start");
        send(8'hA5, "R8 no start");

        // short mode, bit 0 differs but must match
        cyc(1, 0, 0, 8'h00, 0, 8'h00, "R9 start");
        send(8'hA5, "R3 short match ignoring bit0");
        send(8'h11, "R11 data ack");
        ack_level_i = 1'b1;
        send(8'h22, "R11 data nack");
        ack_level_i = 1'b0;
        idle("R9 match held");

        // restart then mismatch
        cyc(1, 0, 0, 8'h00, 0, 8'h00, "R9 start clears match");
        send(8'h24, "R3 short mismatch");
        send(8'hA4, "R7 ignored after mismatch");
        send(8'hA5, "R7 ignored after mismatch");

        // STOP with same-cycle write
        cyc(0, 0, 0, 8'h00, 1, 8'hA5, "R2 write A5");
        cyc(0, 1, 0, 8'h00, 1, 8'hB7, "R10 stop over write");
        cyc(0, 0, 0, 8'h00, 1, 8'hA5, "R2 write A5");
        cyc(0, 1, 0, 8'h00, 0, 8'h00, "R10 stop clears flag");
        send(8'hA4, "R8 after stop");

        // long mode
        mode10_i = 1'b1;
        lo_addr_i = 8'h5A;
        cyc(0, 0, 0, 8'h00, 1, 8'hF3, "R2 write F3");
        cyc(1, 0, 0, 8'h00, 0, 8'h00, "R9 start");
        send(8'hF3, "R4 long first ok no match yet");
        send(8'h5A, "R5 long second ok");
        send(8'h01, "R11 long data");
        cyc(1, 0, 0, 8'h00, 0, 8'h00, "R9 start");
        send(8'hF2, "R4 long bit0 mismatch");
        send(8'h5A, "R7 ignored");
        cyc(1, 0, 0, 8'h00, 0, 8'h00, "R9 start");
        send(8'hF3, "R4 long first ok");
        send(8'h5B, "R5 long second wrong");
        send(8'h5A, "R7 ignored");

        // no acknowledge level on a matching address
        ack_level_i = 1'b1;
        cyc(1, 0, 0, 8'h00, 0, 8'h00, "R9 start");
        send(8'hF3, "R6 match with level high");
        send(8'h5A, "R6 match with level high");
        ack_level_i = 1'b0;

        // START and STOP together, bytes with events
        cyc(1, 1, 1, 8'hF3, 0, 8'h00, "R12 stop wins");
        send(8'hF3, "R12 idle after both");
        cyc(1, 0, 1, 8'hF3, 0, 8'h00, "R12 byte with start dropped");
        send(8'hF3, "R12 first byte still pending");
        cyc(0, 1, 0, 8'h00, 0, 8'h00, "R10 stop");

        // random phase
        lo_addr_i = 8'h3C;
        for (int i = 0; i < 3000; i++) begin
            int r;
            int k;
            bit [7:0] b;
            r = $urandom % 100;
            k = $urandom % 4;
            case (k)
                0: b = m_reg;
                1: b = m_reg ^ 8'h01;
                2: b = lo_addr_i;
                default: b = 8'($urandom);
            endcase
            if (($urandom % 50) == 0) mode10_i = ~mode10_i;
            if (($urandom % 30) == 0) ack_level_i = ~ack_level_i;
            if (r < 4)
                cyc(0, 1, 0, 8'h00, 0, 8'h00, "R10 random stop");
            else if (r < 14)
                cyc(1, 0, 0, 8'h00, 0, 8'h00, "R9 random start");
            else if (r < 16)
                cyc(0, 0, 0, 8'h00, 1, 8'($urandom) | 8'h01, "R2 random write");
            else if (r < 18)
                cyc(1, ($urandom % 2) == 1, 1, b, 0, 8'h00, "R12 random event with byte");
            else if (r < 65)
                send(b, "R3 R4 R5 R6 R7 R11 random byte");
            else
                idle("R8 random idle");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule